// File: doc/BRIEF.md
# Priority Interrupt Level Selector

This block collects the interrupt sources of a processor core into one pending vector of sixteen levels. It reports the most urgent level that beats the core's current priority threshold to the trap logic as an 8-bit trap code and a request flag. The sources are the external level lines and a software-interrupt register. That register carries software-raised levels and two timer-match bits, and both timer-match bits are folded onto level 14.

Evaluation is registered once per clock. A two-state machine holds the request. In `ST_QUIET` no request is outstanding and the stored code is zero. In `ST_RAISED` a request is outstanding with a nonzero stored code. The transition `QUIET->RAISED` fires when an eligible code appears. `RAISED->RAISED` replaces the stored code with a different eligible code. `RAISED->QUIET` fires when nothing is pending at all. When the core enables interrupts, a new request is held back if a trap of higher type is already in progress at a nonzero trap level. A separate halted flag is set when the core asks to idle. Any external line going high clears it, so that a sleeping core wakes.

Top module: `pil_sel`

## Requirements
- R1: The pending vector is the OR of `ext_lvl` and bits 15..1 of `soft_bits`. Bit 0 of `soft_bits` is the tick-match bit and bit 16 is the system-tick-match bit. Neither of them sets its own level. Level 0 of the pending vector comes only from `ext_lvl[0]`.
- R2: If `soft_bits[0]` or `soft_bits[16]` is 1, level 14 is pending.
- R3: When the pending vector is all zero, on the next clock `irq_req` is 0 and `irq_code` is 8'h00, in either state.
- R4: When `int_en` is 1, the selected level is the highest pending level strictly greater than `pri_thresh`. Its candidate code is 8'h40 OR the level number.
- R5: Pending levels less than or equal to `pri_thresh` never produce a request or change the code.
- R6: If `trap_lvl` is nonzero and `trap_type` is numerically greater than the candidate code, outputs keep their values. When `trap_lvl` is zero, `trap_type` has no effect.
- R7: `irq_code` is loaded and `irq_req` set to 1 only when the candidate differs from the stored code. Otherwise both keep their values.
- R8: When `int_en` is 0 and something is pending, `irq_req` and `irq_code` keep their values.
- R9: All outputs are registered. An input change is seen at the outputs after exactly one rising clock edge.
- R10: `halted` goes to 1 on a clock where `idle_req` is 1. It goes to 0 on a clock where any `ext_lvl` bit is 1 that was 0 at the previous clock, and during reset the lines count as 0. Waking wins over `idle_req`.
- R11: During and right after reset (`rst_n` low), `irq_req`, `irq_code` and `halted` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_lvl | input | 16 | External interrupt level lines, one per level |
| soft_bits | input | 17 | Software-interrupt register: bit 0 tick match, bits 15..1 soft levels, bit 16 system-tick match |
| pri_thresh | input | 4 | Current processor priority threshold |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| trap_type | input | 8 | Type of the trap in progress |
| idle_req | input | 1 | Core requests to enter the halted state |
| irq_req | output | 1 | Interrupt request to the core |
| irq_code | output | 8 | Trap code of the request (8'h40 OR level) |
| halted | output | 1 | Core is idle, waiting for an external line |

## Verification
The assertions take every input as a known 0/1 value on each rising edge after reset, held stable between edges. They also rely on the in-progress trap type staying constant within a clock. The bench changes inputs only on falling edges and never drives X or Z. It keeps the pending vector sparse and empty often enough that both states, all three transitions, the nesting block and the disabled hold all occur. Directed steps cover both timer-match bits, a level equal to the threshold, and the wake-versus-idle collision.

// File: rtl/pil_sel_pkg.sv
package pil_sel_pkg;
    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } pil_state_e;
endpackage

// File: rtl/pil_merge.sv
// Builds the pending level vector from the external lines and the softint register.
module pil_merge #(
    parameter int LVLS      = 16,
    parameter int TIMER_LVL = 14
) (
    input  logic [LVLS-1:0] ext_lvl,
    input  logic [LVLS:0]   soft_bits,
    output logic [LVLS-1:0] pend
);
    logic timer_hit;

    assign timer_hit = soft_bits[0] | soft_bits[LVLS];

    always_comb begin
        pend    = ext_lvl | soft_bits[LVLS-1:0];
        pend[0] = ext_lvl[0];           // tick-match bit is not a level
        if (timer_hit) begin
            pend[TIMER_LVL] = 1'b1;     // both timer matches fold here
        end
    end
endmodule

// File: rtl/pil_pick.sv
// Finds the highest pending level strictly above the threshold.
module pil_pick #(
    parameter int LVLS  = 16,
    parameter int LVL_W = 4
) (
    input  logic [LVLS-1:0]  pend,
    input  logic [LVL_W-1:0] thresh,
    output logic             found,
    output logic [LVL_W-1:0] win
);
    logic [LVLS-1:0] hit;

    for (genvar g = 0; g < LVLS; g++) begin : g_hit
        assign hit[g] = pend[g] && (LVL_W'(g) > thresh);
    end

    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int i = 0; i < LVLS; i++) begin
            if (hit[i]) begin
                found = 1'b1;
                win   = LVL_W'(i);
            end
        end
    end
endmodule

// File: rtl/pil_wake.sv
// Halted flag: set by an idle request, cleared by any rising external line.
module pil_wake #(
    parameter int LVLS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVLS-1:0] ext_lvl,
    input  logic            idle_req,
    output logic            halted
);
    logic [LVLS-1:0] ext_q;
    logic            rise;

    assign rise = |(ext_lvl & ~ext_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q  <= '0;
            halted <= 1'b0;
        end else begin
            ext_q <= ext_lvl;
            if (rise) begin
                halted <= 1'b0;
            end else if (idle_req) begin
                halted <= 1'b1;
            end
        end
    end

    p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ext_lvl & ~ext_q)) |=> !halted)
        else $error("wake edge did not clear halted");
endmodule

// File: rtl/pil_sel.sv
module pil_sel #(
    parameter int          LVLS      = 16,
    parameter int          TIMER_LVL = 14,
    parameter int          TL_W      = 3,
    parameter int          CODE_W    = 8,
    parameter logic [7:0]  TRAP_BASE = 8'h40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LVLS-1:0]          ext_lvl,
    input  logic [LVLS:0]            soft_bits,
    input  logic [$clog2(LVLS)-1:0]  pri_thresh,
    input  logic                     int_en,
    input  logic [TL_W-1:0]          trap_lvl,
    input  logic [CODE_W-1:0]        trap_type,
    input  logic                     idle_req,
    output logic                     irq_req,
    output logic [CODE_W-1:0]        irq_code,
    output logic                     halted
);
    import pil_sel_pkg::*;

    localparam int LVL_W = $clog2(LVLS);

    logic [LVLS-1:0]   pend;
    logic              found;
    logic [LVL_W-1:0]  win;
    logic [CODE_W-1:0] cand;
    logic              blocked;
    logic              take;
    logic              empty;

    pil_state_e        state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;

    pil_merge #(.LVLS(LVLS), .TIMER_LVL(TIMER_LVL)) u_merge (
        .ext_lvl   (ext_lvl),
        .soft_bits (soft_bits),
        .pend      (pend)
    );

    pil_pick #(.LVLS(LVLS), .LVL_W(LVL_W)) u_pick (
        .pend   (pend),
        .thresh (pri_thresh),
        .found  (found),
        .win    (win)
    );

    pil_wake #(.LVLS(LVLS)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_lvl  (ext_lvl),
        .idle_req (idle_req),
        .halted   (halted)
    );

    assign cand    = CODE_W'(TRAP_BASE) | CODE_W'(win);
    assign blocked = (trap_lvl != '0) && (trap_type > cand);
    assign empty   = (pend == '0);
    assign take    = int_en && found && !blocked && (cand != code_q);

    // next-state process
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_QUIET: begin
                if (empty) begin
                    code_d = '0;
                end else if (take) begin
                    state_d = ST_RAISED;    // QUIET->RAISED
                    code_d  = cand;
                end
            end
            ST_RAISED: begin
                if (empty) begin
                    state_d = ST_QUIET;     // RAISED->QUIET
                    code_d  = '0;
                end else if (take) begin
                    code_d  = cand;         // RAISED->RAISED
                end
            end
            default: begin
                state_d = ST_QUIET;
                code_d  = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // output process
    always_comb begin
        irq_req  = (state_q == ST_RAISED);
        irq_code = code_q;
    end

    p_clear_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> (!irq_req && irq_code == '0))
        else $error("request not withdrawn on empty vector");

    p_above_thresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_code[LVL_W-1:0] > $past(pri_thresh)))
        else $error("request raised at or below threshold");

    p_nest_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend != '0 && trap_lvl != '0 && trap_type > (CODE_W'(TRAP_BASE) | CODE_W'(win)))
        |=> ($stable(irq_req) && $stable(irq_code)))
        else $error("request changed under a higher trap in progress");

    p_code_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_code[CODE_W-1:LVL_W] == TRAP_BASE[CODE_W-1:LVL_W]))
        else $error("raised request with a code outside the trap base");

    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && pend != '0) |=> ($stable(irq_req) && $stable(irq_code)))
        else $error("outputs changed while interrupts disabled");
endmodule

// File: tb/sim_pil_sel.sv
module sim_pil_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_lvl = '0;
    logic [16:0] soft_bits = '0;
    logic [3:0]  pri_thresh = '0;
    logic        int_en = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic [7:0]  trap_type = '0;
    logic        idle_req = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_code;
    logic        halted;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state
    logic        m_req = 1'b0;
    logic [7:0]  m_code = '0;
    logic        m_halt = 1'b0;
    logic [15:0] m_prev = '0;

    always #10 clk = ~clk;   // 50 MHz

    pil_sel u0 (
        .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_bits(soft_bits),
        .pri_thresh(pri_thresh), .int_en(int_en), .trap_lvl(trap_lvl),
        .trap_type(trap_type), .idle_req(idle_req), .irq_req(irq_req),
        .irq_code(irq_code), .halted(halted)
    );

    function automatic logic [15:0] f_pend(logic [15:0] e, logic [16:0] s);
        logic [15:0] p;
        p = e | {s[15:1], 1'b0};
        if (s[0] || s[16]) p[14] = 1'b1;
        return p;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [15:0] e, logic [16:0] s, logic [3:0] th,
                         logic en, logic [2:0] tl, logic [7:0] tt, logic idl);
        ext_lvl = e; soft_bits = s; pri_thresh = th;
        int_en = en; trap_lvl = tl; trap_type = tt; idle_req = idl;
    endtask

    task automatic model_update();
        logic [15:0] p;
        logic [7:0]  c;
        logic        fnd;
        p = f_pend(ext_lvl, soft_bits);
        if (|(ext_lvl & ~m_prev)) m_halt = 1'b0;
        else if (idle_req) m_halt = 1'b1;
        m_prev = ext_lvl;
        if (p == '0) begin
            m_req = 1'b0; m_code = '0;
        end else if (int_en) begin
            fnd = 1'b0; c = '0;
            for (int i = 15; i > 0; i--) begin
                if (!fnd && p[i] && i > int'(pri_thresh)) begin
                    fnd = 1'b1; c = 8'h40 | 8'(i);
                end
            end
            if (fnd && !(trap_lvl != 0 && trap_type > c) && c != m_code) begin
                m_req = 1'b1; m_code = c;
            end
        end
    endtask

    // one clock: R9 check before the edge, compare after it
    task automatic step(string tag);
        #1;
        chk("R9", "req before edge", int'(irq_req), int'(m_req));
        chk("R9", "code before edge", int'(irq_code), int'(m_code));
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk(tag, "irq_req", int'(irq_req), int'(m_req));
        chk(tag, "irq_code", int'(irq_code), int'(m_code));
        chk(tag == "R10" ? "R10" : tag, "halted", int'(halted), int'(m_halt));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "irq_req", int'(irq_req), 0);
        chk("R11", "irq_code", int'(irq_code), 0);
        chk("R11", "halted", int'(halted), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "code after release", int'(irq_code), 0);

        // R4: single external line above threshold
        drive(16'h0020, '0, 4'd2, 1'b1, 3'd0, 8'h00, 1'b0); step("R4");
        // R4: higher line replaces lower
        drive(16'h0820, '0, 4'd2, 1'b1, 3'd0, 8'h00, 1'b0); step("R4");
        // R7: same candidate, nothing new
        step("R7");
        // R3: empty vector withdraws
        drive('0, '0, 4'd2, 1'b1, 3'd0, 8'h00, 1'b0); step("R3");
        // R2: tick-match bit alone -> level 14
        drive('0, 17'h00001, 4'd0, 1'b1, 3'd0, 8'h00, 1'b0); step("R2");
        drive('0, '0, 4'd0, 1'b1, 3'd0, 8'h00, 1'b0); step("R3");
        // R2: system-tick-match bit alone -> level 14
        drive('0, 17'h10000, 4'd0, 1'b1, 3'd0, 8'h00, 1'b0); step("R2");
        drive('0, '0, 4'd0, 1'b1, 3'd0, 8'h00, 1'b0); step("R3");
        // R1: soft level 9 from the register
        drive('0, 17'h00200, 4'd3, 1'b1, 3'd0, 8'h00, 1'b0); step("R1");
        // R5: level equal to threshold ignored
        drive('0, '0, 4'd0, 1'b1, 3'd0, 8'h00, 1'b0); step("R3");
        drive(16'h0080, '0, 4'd7, 1'b1, 3'd0, 8'h00, 1'b0); step("R5");
        // R6: nested higher trap blocks, then tl=0 lets through
        drive(16'h0080, '0, 4'd2, 1'b1, 3'd1, 8'h50, 1'b0); step("R6");
        drive(16'h0080, '0, 4'd2, 1'b1, 3'd0, 8'h50, 1'b0); step("R6");
        // R8: disabled keeps state
        drive(16'h8000, '0, 4'd0, 1'b0, 3'd0, 8'h00, 1'b0); step("R8");
        // R10: idle then wake; collision wake wins
        drive(16'h8000, '0, 4'd0, 1'b0, 3'd0, 8'h00, 1'b1); step("R10");
        drive(16'h8001, '0, 4'd0, 1'b0, 3'd0, 8'h00, 1'b1); step("R10");
        drive(16'h8001, '0, 4'd0, 1'b0, 3'd0, 8'h00, 1'b1); step("R10");
        drive(16'h8003, '0, 4'd0, 1'b0, 3'd0, 8'h00, 1'b0); step("R10");

        // R4: constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] e;
            logic [16:0] s;
            e = ($urandom % 3 == 0) ? 16'h0 : 16'($urandom & $urandom & $urandom);
            s = ($urandom % 3 == 0) ? 17'h0 : 17'($urandom & $urandom & $urandom);
            drive(e, s, 4'($urandom), ($urandom % 6) != 0,
                  ($urandom % 2) ? 3'd0 : 3'($urandom),
                  ($urandom % 2) ? 8'($urandom) : (8'h40 | 8'($urandom % 16)),
                  ($urandom % 5) == 0);
            step("R4");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule